// File: doc/BRIEF.md
# Privilege-filtered address match unit

This block watches the core's instruction fetch and its load/store traffic and compares both against the address word of every hardware trigger. A trigger takes part in matching only when its control word says it is an address-match trigger, either the legacy kind (type 2) or the extended kind (type 6). The trigger must also have a privilege enable and an access kind enabled. Its per-privilege enable bit must then admit the level the hart is running at.

The outputs are purely combinational on the current inputs. A hit is meant to be turned into a breakpoint exception request by the pipeline, and it is taken before the matching instruction retires or the matching access writes or returns data. When more than one trigger matches in a cycle, the lowest-numbered one is reported. Range matching, mask matching, chaining and any action other than a breakpoint are not part of this block.

Top module: `privmatch_unit`

## Requirements
- R1: A trigger can hit only if at least one of its privilege enable bits is set and at least one of its access bits (bit 0 load, bit 1 store, bit 2 execute) is set.
- R2: An execute hit needs `fetch_vld_i` high, control bit 2 set and `fetch_pc_i` exactly equal to the trigger address; a neighbouring address does not hit.
- R3: A data hit needs `mem_vld_i` high and the exact address, with control bit 0 enabling reads (`mem_wr_i`=0) and bit 1 enabling writes (`mem_wr_i`=1).
- R4: Without virtualization (`virt_i`=0), a hit is admitted by control bit 3+priv, where priv 0 is user (bit 3), 1 is supervisor (bit 4) and 3 is machine (bit 6). The reserved priv value 2 never hits.
- R5: For type 6 triggers with `virt_i`=1, the hit is admitted by bit 23 for priv 0 (virtual user) or bit 24 for priv 1 (virtual supervisor). Other priv values never hit. Bits 23/24 do not admit anything outside virtualization.
- R6: A type 2 trigger never hits while `virt_i` is 1.
- R7: The trigger type sits in the top four control bits (31:28 at XLEN 32). Any type other than 2 or 6 never hits.
- R8: With neither `fetch_vld_i` nor `mem_vld_i` high, `hit_o` is 0 and `hit_idx_o` is 0.
- R9: When several triggers hit in the same cycle, `hit_idx_o` gives the lowest index. It is 0 when there is no hit.
- R10: A fetch and a data access may be presented together, and a match on either one makes the trigger hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_vld_i | input | 1 | Instruction fetch address is valid |
| fetch_pc_i | input | XLEN | Fetch program counter |
| mem_vld_i | input | 1 | Load/store access is valid |
| mem_addr_i | input | XLEN | Load/store address |
| mem_wr_i | input | 1 | Access kind: 1 store, 0 load |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Hart runs virtualized |
| tctrl_i | input | NUM_TRIG*XLEN | Control words, trigger i at bits i*XLEN +: XLEN |
| taddr_i | input | NUM_TRIG*XLEN | Address words, same packing |
| hit_o | output | 1 | Some trigger requests a breakpoint |
| hit_idx_o | output | IDXW | Lowest index of the hitting triggers |

## Verification
The bench builds the unit at its defaults of XLEN 32 and two triggers. That puts the type field at bits 31:28 and makes the priority between two simultaneous hits observable at the ports. With two triggers, one trigger can be disabled by its type or by virtualization while the other still hits, which shows that index 1 is reported only when trigger 0 drops out. Sweeps over all sixteen type codes and over every privilege/enable-bit pairing cover the qualification rules exhaustively at this width.

// File: rtl/pmatch_pkg.sv
package pmatch_pkg;

    // Access kind enables in the control word
    localparam int unsigned LD_BIT      = 0;
    localparam int unsigned ST_BIT      = 1;
    localparam int unsigned EX_BIT      = 2;
    // Base of native privilege enables: bit = base + priv
    localparam int unsigned PRIV_BASE   = 3;
    // Base of virtual privilege enables (type 6 only)
    localparam int unsigned VPRIV_BASE  = 23;
    localparam int unsigned TYPE_W      = 4;

    localparam logic [TYPE_W-1:0] TYPE_LEGACY = 4'd2;
    localparam logic [TYPE_W-1:0] TYPE_EXT    = 4'd6;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_LEGACY = 2'd1,
        KIND_EXT    = 2'd2
    } trig_kind_e;

endpackage

// File: rtl/trig_qualify.sv
module trig_qualify
    import pmatch_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] ctrl_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    output trig_kind_e      kind_o,
    output logic            armed_o,
    output logic            priv_ok_o
);

    localparam int unsigned TYPE_LSB = XLEN - TYPE_W;

    logic [TYPE_W-1:0] type_f;
    logic              mode_any;
    logic              rwx_any;
    logic              unused_ctrl;

    assign unused_ctrl = ^ctrl_i;

    always_comb begin
        type_f = ctrl_i[TYPE_LSB +: TYPE_W];
        if (type_f == TYPE_LEGACY) begin
            kind_o = KIND_LEGACY;
        end else if (type_f == TYPE_EXT) begin
            kind_o = KIND_EXT;
        end else begin
            kind_o = KIND_NONE;
        end

        mode_any = ctrl_i[PRIV_BASE + 0] | ctrl_i[PRIV_BASE + 1] | ctrl_i[PRIV_BASE + 3];
        if (kind_o == KIND_EXT) begin
            mode_any = mode_any | ctrl_i[VPRIV_BASE + 0] | ctrl_i[VPRIV_BASE + 1];
        end
        rwx_any = ctrl_i[LD_BIT] | ctrl_i[ST_BIT] | ctrl_i[EX_BIT];
        armed_o = (kind_o != KIND_NONE) && mode_any && rwx_any;

        priv_ok_o = 1'b0;
        if (kind_o != KIND_NONE) begin
            if (virt_i) begin
                if (kind_o == KIND_EXT) begin
                    case (priv_i)
                        PRIV_U:  priv_ok_o = ctrl_i[VPRIV_BASE + 0];
                        PRIV_S:  priv_ok_o = ctrl_i[VPRIV_BASE + 1];
                        default: priv_ok_o = 1'b0;
                    endcase
                end
            end else begin
                case (priv_i)
                    PRIV_U:  priv_ok_o = ctrl_i[PRIV_BASE + 0];
                    PRIV_S:  priv_ok_o = ctrl_i[PRIV_BASE + 1];
                    PRIV_M:  priv_ok_o = ctrl_i[PRIV_BASE + 3];
                    default: priv_ok_o = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/trig_compare.sv
module trig_compare #(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      rwx_i,
    input  logic [XLEN-1:0] taddr_i,
    input  logic            fetch_vld_i,
    input  logic [XLEN-1:0] fetch_pc_i,
    input  logic            mem_vld_i,
    input  logic [XLEN-1:0] mem_addr_i,
    input  logic            mem_wr_i,
    output logic            exec_match_o,
    output logic            data_match_o
);

    logic kind_en;

    always_comb begin
        exec_match_o = fetch_vld_i && rwx_i[2] && (fetch_pc_i == taddr_i);
        kind_en      = mem_wr_i ? rwx_i[1] : rwx_i[0];
        data_match_o = mem_vld_i && kind_en && (mem_addr_i == taddr_i);
    end

endmodule

// File: rtl/hit_prio.sv
module hit_prio #(
    parameter int unsigned NUM_TRIG = 2,
    parameter int unsigned IDXW     = 1
) (
    input  logic [NUM_TRIG-1:0] req_i,
    output logic                hit_o,
    output logic [IDXW-1:0]     idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/privmatch_unit.sv
module privmatch_unit
    import pmatch_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 2,
    localparam int unsigned IDXW    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                     fetch_vld_i,
    input  logic [XLEN-1:0]          fetch_pc_i,
    input  logic                     mem_vld_i,
    input  logic [XLEN-1:0]          mem_addr_i,
    input  logic                     mem_wr_i,
    input  logic [1:0]               priv_i,
    input  logic                     virt_i,
    input  logic [NUM_TRIG*XLEN-1:0] tctrl_i,
    input  logic [NUM_TRIG*XLEN-1:0] taddr_i,
    output logic                     hit_o,
    output logic [IDXW-1:0]          hit_idx_o
);

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } result_t;

    logic [NUM_TRIG-1:0] trig_hit;
    logic                enc_hit;
    logic [IDXW-1:0]     enc_idx;
    result_t             res_d;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        trig_kind_e kind;
        logic       armed;
        logic       priv_ok;
        logic       exec_m;
        logic       data_m;

        trig_qualify #(.XLEN(XLEN)) u_qual (
            .ctrl_i    (tctrl_i[g*XLEN +: XLEN]),
            .priv_i    (priv_i),
            .virt_i    (virt_i),
            .kind_o    (kind),
            .armed_o   (armed),
            .priv_ok_o (priv_ok)
        );

        trig_compare #(.XLEN(XLEN)) u_cmp (
            .rwx_i        (tctrl_i[g*XLEN +: 3]),
            .taddr_i      (taddr_i[g*XLEN +: XLEN]),
            .fetch_vld_i  (fetch_vld_i),
            .fetch_pc_i   (fetch_pc_i),
            .mem_vld_i    (mem_vld_i),
            .mem_addr_i   (mem_addr_i),
            .mem_wr_i     (mem_wr_i),
            .exec_match_o (exec_m),
            .data_match_o (data_m)
        );

        assign trig_hit[g] = (kind != KIND_NONE) && armed && priv_ok && (exec_m || data_m);
    end

    hit_prio #(.NUM_TRIG(NUM_TRIG), .IDXW(IDXW)) u_prio (
        .req_i (trig_hit),
        .hit_o (enc_hit),
        .idx_o (enc_idx)
    );

    always_comb begin
        res_d     = '0;
        res_d.hit = enc_hit;
        res_d.idx = enc_hit ? enc_idx : '0;
    end

    assign hit_o     = res_d.hit;
    assign hit_idx_o = res_d.idx;

endmodule

// File: rtl/privmatch_chk.sv
module privmatch_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 2,
    parameter int unsigned IDXW     = 1
) (
    input logic                     fetch_vld_i,
    input logic                     mem_vld_i,
    input logic [1:0]               priv_i,
    input logic                     virt_i,
    input logic [NUM_TRIG*XLEN-1:0] tctrl_i,
    input logic [NUM_TRIG-1:0]      trig_hit,
    input logic                     hit_o,
    input logic [IDXW-1:0]          hit_idx_o
);

    always_comb begin
        if (!$isunknown({fetch_vld_i, mem_vld_i, hit_o})) begin
            a_r8_idle_no_hit: assert (fetch_vld_i || mem_vld_i || !hit_o)
                else $error("R8: hit with no valid input");
        end
        if (!$isunknown({hit_o, hit_idx_o, trig_hit})) begin
            a_r9_idx_is_hitting: assert (!hit_o || trig_hit[hit_idx_o])
                else $error("R9: reported index does not hit");
            a_r9_vector_agrees: assert (hit_o == (trig_hit != '0))
                else $error("R9: hit flag disagrees with trigger hits");
            for (int j = 0; j < NUM_TRIG; j++) begin
                if (hit_o && (j < int'(hit_idx_o))) begin
                    a_r9_lowest_wins: assert (!trig_hit[j])
                        else $error("R9: lower trigger %0d also hits", j);
                end
            end
        end
        for (int i = 0; i < NUM_TRIG; i++) begin
            logic [XLEN-1:0] c;
            logic [3:0]      t;
            c = tctrl_i[i*XLEN +: XLEN];
            t = c[XLEN-1 -: 4];
            if (!$isunknown({c, trig_hit[i], virt_i, priv_i})) begin
                a_r6_legacy_virt_silent: assert (!(virt_i && (t == 4'd2) && trig_hit[i]))
                    else $error("R6: type 2 trigger %0d hit while virtualized", i);
                a_r7_other_type_silent: assert (!(((t != 4'd2) && (t != 4'd6)) && trig_hit[i]))
                    else $error("R7: trigger %0d of type %0d hit", i, t);
                a_r4_native_priv_bit: assert (virt_i || !trig_hit[i] || c[3 + int'(priv_i)])
                    else $error("R4: trigger %0d hit without its privilege bit", i);
                a_r1_armed: assert (!trig_hit[i] || (c[2:0] != 3'b000))
                    else $error("R1: trigger %0d hit with no access bit", i);
            end
        end
    end

endmodule

bind privmatch_unit privmatch_chk #(
    .XLEN     (XLEN),
    .NUM_TRIG (NUM_TRIG),
    .IDXW     (IDXW)
) u_chk (
    .fetch_vld_i (fetch_vld_i),
    .mem_vld_i   (mem_vld_i),
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .tctrl_i     (tctrl_i),
    .trig_hit    (trig_hit),
    .hit_o       (hit_o),
    .hit_idx_o   (hit_idx_o)
);

// File: tb/privmatch_unit_bench.sv
module privmatch_unit_bench;

    localparam int XL = 32;
    localparam int NT = 2;
    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2000;

    typedef struct packed {
        logic        fv;
        logic [31:0] pc;
        logic        mv;
        logic [31:0] ma;
        logic        wr;
        logic [1:0]  pv;
        logic        vt;
        logic [31:0] c0;
        logic [31:0] a0;
        logic [31:0] c1;
        logic [31:0] a1;
        logic        eh;
        logic        ei;
        logic [3:0]  rq;
    } vec_t;

    // type in 31:28, VS 24, VU 23, M 6, S 4, U 3, X 2, ST 1, LD 0
    function automatic logic [31:0] mkc(input int t, input bit vu, input bit vs, input bit m,
                                        input bit s, input bit u, input bit x, input bit st,
                                        input bit ld);
        logic [31:0] r;
        r = '0;
        r[31:28] = 4'(t);
        r[24] = vs; r[23] = vu; r[6] = m; r[4] = s; r[3] = u;
        r[2] = x; r[1] = st; r[0] = ld;
        return r;
    endfunction

    function automatic vec_t mkv(input bit fv, input logic [31:0] pc, input bit mv,
                                 input logic [31:0] ma, input bit wr, input int pv, input bit vt,
                                 input logic [31:0] c0, input logic [31:0] a0,
                                 input logic [31:0] c1, input logic [31:0] a1,
                                 input bit eh, input bit ei, input int rq);
        vec_t v;
        v.fv = fv; v.pc = pc; v.mv = mv; v.ma = ma; v.wr = wr; v.pv = 2'(pv); v.vt = vt;
        v.c0 = c0; v.a0 = a0; v.c1 = c1; v.a1 = a1; v.eh = eh; v.ei = ei; v.rq = 4'(rq);
        return v;
    endfunction

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        mkv(1, A,   0, 0, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A, 0, 0, 1, 0, 2),  // R2 exact fetch
        mkv(1, A+4, 0, 0, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A, 0, 0, 0, 0, 2),  // R2 neighbour
        mkv(1, A,   0, 0, 0, 3, 0, mkc(2,0,0,1,0,0,0,0,1), A, 0, 0, 0, 0, 2),  // R2 no exec bit
        mkv(0, 0,   1, A, 0, 3, 0, mkc(2,0,0,1,0,0,0,0,1), A, 0, 0, 1, 0, 3),  // R3 load
        mkv(0, 0,   1, A, 1, 3, 0, mkc(2,0,0,1,0,0,0,0,1), A, 0, 0, 0, 0, 3),  // R3 store vs load-only
        mkv(0, 0,   1, A, 1, 3, 0, mkc(2,0,0,1,0,0,0,1,0), A, 0, 0, 1, 0, 3),  // R3 store
        mkv(0, 0,   1, A, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A, 0, 0, 0, 0, 3),  // R3 exec-only on data
        mkv(1, A,   0, 0, 0, 0, 0, mkc(2,0,0,0,0,1,1,0,0), A, 0, 0, 1, 0, 4),  // R4 user
        mkv(1, A,   0, 0, 0, 0, 0, mkc(2,0,0,1,1,0,1,0,0), A, 0, 0, 0, 0, 4),  // R4 user blocked
        mkv(1, A,   0, 0, 0, 1, 0, mkc(2,0,0,0,1,0,1,0,0), A, 0, 0, 1, 0, 4),  // R4 supervisor
        mkv(1, A,   0, 0, 0, 2, 0, mkc(2,0,0,1,1,1,1,0,0), A, 0, 0, 0, 0, 4),  // R4 reserved priv
        mkv(1, A,   0, 0, 0, 3, 0, mkc(2,0,0,0,0,0,1,1,1), A, 0, 0, 0, 0, 1),  // R1 no mode bit
        mkv(0, 0,   1, A, 0, 3, 0, mkc(2,0,0,1,1,1,0,0,0), A, 0, 0, 0, 0, 1),  // R1 no access bit
        mkv(1, A,   0, 0, 0, 0, 1, mkc(2,0,0,0,0,1,1,0,0), A, 0, 0, 0, 0, 6),  // R6 legacy virt
        mkv(1, A,   0, 0, 0, 0, 1, mkc(6,1,0,0,0,0,1,0,0), A, 0, 0, 1, 0, 5),  // R5 VU
        mkv(1, A,   0, 0, 0, 0, 1, mkc(6,0,0,0,0,1,1,0,0), A, 0, 0, 0, 0, 5),  // R5 U ignored in virt
        mkv(1, A,   0, 0, 0, 1, 1, mkc(6,0,1,0,0,0,1,0,0), A, 0, 0, 1, 0, 5),  // R5 VS
        mkv(1, A,   0, 0, 0, 3, 1, mkc(6,1,1,1,0,0,1,0,0), A, 0, 0, 0, 0, 5),  // R5 machine in virt
        mkv(1, A,   0, 0, 0, 0, 0, mkc(6,0,0,0,0,1,1,0,0), A, 0, 0, 1, 0, 4),  // R4 type 6 native
        mkv(1, A,   0, 0, 0, 0, 0, mkc(6,1,0,0,0,0,1,0,0), A, 0, 0, 0, 0, 5),  // R5 VU outside virt
        mkv(0, 0,   1, A, 1, 1, 1, mkc(6,0,1,0,0,0,0,1,0), A, 0, 0, 1, 0, 5),  // R5 virt store
        mkv(1, A,   0, 0, 0, 3, 0, mkc(5,0,0,1,0,0,1,0,0), A, 0, 0, 0, 0, 7),  // R7 type 5
        mkv(1, A,   0, 0, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A,
                                   mkc(2,0,0,1,0,0,1,0,0), A, 1, 0, 9),          // R9 both
        mkv(1, A,   0, 0, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), B,
                                   mkc(2,0,0,1,0,0,1,0,0), A, 1, 1, 9),          // R9 only t1
        mkv(1, A,   0, 0, 0, 0, 1, mkc(2,0,0,0,0,1,1,0,0), A,
                                   mkc(6,1,0,0,0,0,1,0,0), A, 1, 1, 6),          // R6 t0 drops, R9
        mkv(1, A,   1, B, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A,
                                   mkc(2,0,0,1,0,0,0,0,1), B, 1, 0, 10),         // R10 both
        mkv(1, A+8, 1, B, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,0), A,
                                   mkc(2,0,0,1,0,0,0,0,1), B, 1, 1, 10),         // R10 data only
        mkv(0, A,   0, A, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,1), A, 0, 0, 0, 0, 8)   // R8 idle
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_vld, mem_vld, mem_wr, virt;
    logic [XL-1:0]     fetch_pc, mem_addr;
    logic [1:0]        priv;
    logic [NT*XL-1:0]  tctrl, taddr;
    logic              hit;
    logic [0:0]        hit_idx;
    int                n_run = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    privmatch_unit #(.XLEN(XL), .NUM_TRIG(NT)) u_privmatch_unit (
        .fetch_vld_i (fetch_vld),
        .fetch_pc_i  (fetch_pc),
        .mem_vld_i   (mem_vld),
        .mem_addr_i  (mem_addr),
        .mem_wr_i    (mem_wr),
        .priv_i      (priv),
        .virt_i      (virt),
        .tctrl_i     (tctrl),
        .taddr_i     (taddr),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx)
    );

    task automatic check(input bit eh, input bit ei, input int rq);
        n_run++;
        if (hit !== eh || hit_idx !== ei) begin
            n_fail++;
            $display("FAIL R%0d: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     rq, hit, hit_idx, eh, ei);
        end
    endtask

    task automatic apply(input vec_t v);
        @(posedge clk);
        #1;
        fetch_vld = v.fv; fetch_pc = v.pc; mem_vld = v.mv; mem_addr = v.ma; mem_wr = v.wr;
        priv = v.pv; virt = v.vt;
        tctrl = {v.c1, v.c0};
        taddr = {v.a1, v.a0};
        @(negedge clk);
        check(v.eh, v.ei, int'(v.rq));
    endtask

    initial begin
        fetch_vld = 0; fetch_pc = A; mem_vld = 0; mem_addr = A; mem_wr = 0;
        priv = 2'd3; virt = 0;
        tctrl = {32'h0, mkc(2,0,0,1,0,0,1,0,1)};
        taddr = {32'h0, A};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 1'b0, 8);  // R8: idle during reset
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) apply(VECS[k]);

        // R4: each native enable bit against every privilege value
        for (int p = 0; p < 4; p++) begin
            if (p != 2) begin
                for (int q = 0; q < 4; q++) begin
                    logic [31:0] c;
                    c = mkc(2, 0, 0, p == 3, p == 1, p == 0, 1, 0, 0);
                    apply(mkv(1, A, 0, 0, 0, q, 0, c, A, 0, 0, q == p, 0, 4));
                end
            end
        end

        // R7: every type code, only 2 and 6 may hit
        for (int t = 0; t < 16; t++) begin
            apply(mkv(1, A, 0, 0, 0, 3, 0, mkc(t,0,0,1,0,0,1,0,0), A, 0, 0,
                      (t == 2) || (t == 6), 0, 7));
        end

        // R8: drop both valids after a hit
        apply(mkv(1, A, 1, A, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,1), A, 0, 0, 1, 0, 8));
        apply(mkv(0, A, 0, A, 0, 3, 0, mkc(2,0,0,1,0,0,1,0,1), A, 0, 0, 0, 0, 8));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule